// File: doc/BRIEF.md
# Flash Interrupt and Status Unit

This block keeps the interrupt-status, controller-status and first system-configuration registers of a flash controller. Host software reaches them over a simple register port: a write strobe, a read strobe, a 2-bit register select and 16-bit data. The unit also watches the command register and decides whether each command may start. Flash operations outside the block report back through two kinds of pulse. Completion pulses (reset, erase, program, load) set bits in interrupt status. Error pulses set bits in controller status.

A master interrupt bit sits at the top of interrupt status. While it is set, new commands are refused. Software acknowledges it by writing a mask that is ANDed into the register. When the acknowledge leaves the master bit at zero, the error bits are also cleared. The interrupt pin is the master bit, optionally inverted by a polarity bit in configuration. A ready pin follows another configuration bit. Recognised opcodes are passed on through a one-cycle accept strobe together with the opcode. Unknown opcodes are flagged as errors, and the two reset opcodes are carried out inside the unit.

Top module: `flash_irq_status_unit`

## Requirements
- R1: After the asynchronous reset: interrupt status = 0x8080, controller status = 0x0000, configuration reads 0x40C0, irq_o = 1, ready_o = 1 and the stored command is 0.
- R2: A completion pulse on done_i[0] (reset), done_i[1] (erase), done_i[2] (program) or done_i[3] (load) sets interrupt-status bit 4, 5, 6 or 7 respectively. On the same clock edge it also sets master bit 15. Bits already set are kept.
- R3: An error pulse on err_i[0] (command), err_i[1] (erase), err_i[2] (program) or err_i[3] (load) sets controller-status bit 10, 11, 12 or 13 respectively. These bits stay set until cleared by R4 or R8.
- R4: A write to select 0 (interrupt) ANDs the written data into interrupt status. If bit 15 of the ANDed value is 0, controller-status bits 10 to 13 are cleared; otherwise they are kept.
- R5: A write to select 3 (command) while interrupt-status bit 15 is set has no effect at all. There is no accept strobe, no error bit is set, and the stored command does not change.
- R6: A command write with bit 15 clear stores the opcode. If the opcode is one of 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30 or 0x65, cmd_accept_o is high for the one cycle after the write, with cmd_code_o equal to the opcode.
- R7: Any other opcode (except those of R8) written with bit 15 clear sets controller-status bit 10 and interrupt-status bit 15, and does not raise cmd_accept_o.
- R8: Opcode 0xF0 or 0xF3 written with bit 15 clear, or a pulse on warm_rst_i, sets interrupt status to 0x8010, controller status to 0, configuration to 0x40C0 and the stored command to 0, with no accept strobe.
- R9: irq_o equals interrupt-status bit 15 XOR the inverse of configuration bit 6.
- R10: A write to select 2 stores all 16 bits of configuration. A read of select 2 returns it with bits 4:0 forced to 0. ready_o equals configuration bit 7.
- R11: rdata_o is loaded on the clock edge where reg_rd_i is high, from select 0 (interrupt), 1 (status), 2 (configuration) or 3 (stored command). It holds its value otherwise. Writes to select 1 are ignored.
- R12: When a completion or error pulse arrives in the same cycle as an acknowledge write, the pulse's bits are set after the AND and after the error clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 interrupt, 1 status, 2 configuration, 3 command |
| reg_wdata_i | input | 16 | Write data |
| done_i | input | 4 | Completion pulses: reset, erase, program, load |
| err_i | input | 4 | Error pulses: command, erase, program, load |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt line, polarity set by configuration bit 6 |
| ready_o | output | 1 | Ready line, configuration bit 7 |
| cmd_accept_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_code_o | output | 16 | Stored command opcode |

## Verification
Some properties are checked on every cycle. An accept strobe only ever follows a command write made while the master bit was clear. A refused write leaves the stored opcode alone. Any completion pulse leaves the master bit set. An acknowledge that drops the master bit empties the error field. Error bits never fall without an acknowledge or reset. The ready line moves only after a configuration write or reset. Other behaviour needs the bench's scenarios: the exact register values after a sequence of mixed pulses and partial acknowledges, the opcode classification, both interrupt polarities, the masked configuration read-back, and the equivalence of the reset opcodes and the warm reset pin.

// File: rtl/fisu_pkg.sv
package fisu_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 2;
  localparam int N_EVT      = 4;
  localparam int DONE_LSB   = 4;
  localparam int ERR_LSB    = 10;
  localparam int MASTER_BIT = 15;
  localparam int POL_BIT    = 6;
  localparam int RDY_BIT    = 7;
  localparam int CFG_HIDE   = 5;

  typedef logic [DATA_W-1:0] word_t;

  localparam word_t INT_COLD = 16'h8080;
  localparam word_t INT_WARM = 16'h8010;
  localparam word_t CFG_RST  = 16'h40C0;
  localparam word_t CFG_RD_MASK = ~word_t'((1 << CFG_HIDE) - 1);
  localparam word_t ERR_MASK = word_t'(((1 << N_EVT) - 1) << ERR_LSB);

  localparam word_t OP_RST_CORE = 16'h00F0;
  localparam word_t OP_RST_ALL  = 16'h00F3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_INT  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_CMD  = 2'd3
  } sel_e;

  function automatic logic op_known(word_t op);
    case (op)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fisu_int_reg.sv
module fisu_int_reg
  import fisu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_i,
  input  logic             ack_we_i,
  input  word_t            ack_data_i,
  input  logic [N_EVT-1:0] done_i,
  input  logic             unk_i,
  output word_t            q_o,
  output logic             ack_clr_o
);
  word_t q, masked, set, nxt;

  always_comb begin
    masked = ack_we_i ? (q & ack_data_i) : q;
    set = '0;
    for (int i = 0; i < N_EVT; i++) set[DONE_LSB+i] = done_i[i];
    set[MASTER_BIT] = (|done_i) | unk_i;
    // events land after the acknowledge mask
    nxt = warm_i ? INT_WARM : (masked | set);
  end

  assign ack_clr_o = ack_we_i & ~masked[MASTER_BIT];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= INT_COLD;
    else         q <= nxt;

  assign q_o = q;

  // R2
  done_sets_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|done_i) && !warm_i) |=> q[MASTER_BIT]);
  // R8
  warm_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_i |=> (q == INT_WARM));
  // R12
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && done_i[1] && !warm_i) |=> q[DONE_LSB+1]);
endmodule

// File: rtl/fisu_err_reg.sv
module fisu_err_reg
  import fisu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_i,
  input  logic             clr_i,
  input  logic [N_EVT-1:0] err_i,
  input  logic             unk_i,
  output word_t            q_o
);
  word_t q, set, nxt;

  always_comb begin
    set = '0;
    for (int i = 0; i < N_EVT; i++) set[ERR_LSB+i] = err_i[i];
    set[ERR_LSB] = set[ERR_LSB] | unk_i;
    nxt = warm_i ? '0 : ((clr_i ? (q & ~ERR_MASK) : q) | set);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= nxt;

  assign q_o = q;

  // R4
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (err_i == '0) && !unk_i && !warm_i) |=> ((q & ERR_MASK) == '0));
  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !warm_i) |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/fisu_cfg_reg.sv
module fisu_cfg_reg
  import fisu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  warm_i,
  input  logic  we_i,
  input  word_t wdata_i,
  input  logic  master_i,
  output word_t q_o,
  output logic  irq_o,
  output logic  ready_o
);
  word_t q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     q <= CFG_RST;
    else if (warm_i) q <= CFG_RST;
    else if (we_i)   q <= wdata_i;

  assign q_o     = q;
  assign irq_o   = master_i ^ ~q[POL_BIT];
  assign ready_o = q[RDY_BIT];

  // R10
  ready_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ready_o) |-> $past(we_i || warm_i));
endmodule

// File: rtl/fisu_cmd_gate.sv
module fisu_cmd_gate
  import fisu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  warm_i,
  input  logic  we_i,
  input  word_t op_i,
  input  logic  busy_i,
  output logic  accept_o,
  output word_t code_o,
  output logic  unk_o,
  output logic  rst_cmd_o
);
  logic  take, known, is_rst, accept_q;
  word_t code_q;

  assign take      = we_i & ~busy_i;
  assign is_rst    = (op_i == OP_RST_CORE) | (op_i == OP_RST_ALL);
  assign known     = op_known(op_i);
  assign rst_cmd_o = take & is_rst;
  assign unk_o     = take & ~is_rst & ~known;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_q   <= '0;
      accept_q <= 1'b0;
    end else begin
      accept_q <= take & known & ~warm_i;
      if (warm_i || rst_cmd_o) code_q <= '0;
      else if (take)           code_q <= op_i;
    end

  assign accept_o = accept_q;
  assign code_o   = code_q;

  // R5
  accept_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(we_i && !busy_i));
  // R5
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && busy_i && !warm_i) |=> (!accept_o && $stable(code_o)));
endmodule

// File: rtl/flash_irq_status_unit.sv
module flash_irq_status_unit
  import fisu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              reg_we_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [N_EVT-1:0]  done_i,
  input  logic [N_EVT-1:0]  err_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              ready_o,
  output logic              cmd_accept_o,
  output logic [DATA_W-1:0] cmd_code_o
);
  sel_e  sel;
  logic  we_int, we_cfg, we_cmd;
  logic  unk, rst_cmd, warm, ack_clr;
  word_t int_q, stat_q, cfg_q, code_q, rdata_q;

  assign sel    = sel_e'(reg_addr_i);
  assign we_int = reg_we_i & (sel == SEL_INT);
  assign we_cfg = reg_we_i & (sel == SEL_CFG);
  assign we_cmd = reg_we_i & (sel == SEL_CMD);
  assign warm   = warm_rst_i | rst_cmd;

  fisu_cmd_gate u_gate (
    .clk_i, .rst_ni, .warm_i(warm_rst_i), .we_i(we_cmd), .op_i(reg_wdata_i),
    .busy_i(int_q[MASTER_BIT]), .accept_o(cmd_accept_o), .code_o(code_q),
    .unk_o(unk), .rst_cmd_o(rst_cmd)
  );

  fisu_int_reg u_int (
    .clk_i, .rst_ni, .warm_i(warm), .ack_we_i(we_int), .ack_data_i(reg_wdata_i),
    .done_i, .unk_i(unk), .q_o(int_q), .ack_clr_o(ack_clr)
  );

  fisu_err_reg u_err (
    .clk_i, .rst_ni, .warm_i(warm), .clr_i(ack_clr), .err_i, .unk_i(unk),
    .q_o(stat_q)
  );

  fisu_cfg_reg u_cfg (
    .clk_i, .rst_ni, .warm_i(warm), .we_i(we_cfg), .wdata_i(reg_wdata_i),
    .master_i(int_q[MASTER_BIT]), .q_o(cfg_q), .irq_o, .ready_o
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_q <= '0;
    else if (reg_rd_i)
      case (sel)
        SEL_INT:  rdata_q <= int_q;
        SEL_STAT: rdata_q <= stat_q;
        SEL_CFG:  rdata_q <= cfg_q & CFG_RD_MASK;
        default:  rdata_q <= code_q;
      endcase

  assign rdata_o    = rdata_q;
  assign cmd_code_o = code_q;

  // R7
  unknown_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unk && !warm_rst_i) |=> (stat_q[ERR_LSB] && int_q[MASTER_BIT] && !cmd_accept_o));
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(rdata_o));
endmodule

// File: tb/flash_irq_status_unit_test.sv
module flash_irq_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm = 1'b0, we = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  done = '0, err = '0;
  logic [15:0] rdata, code;
  logic        irq, ready, accept;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_irq_status_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .reg_we_i(we), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .done_i(done), .err_i(err),
    .rdata_o(rdata), .irq_o(irq), .ready_o(ready), .cmd_accept_o(accept),
    .cmd_code_o(code)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [15:0] wd;
    logic [3:0]  done;
    logic [3:0]  err;
    logic [15:0] e_int;
    logic [15:0] e_stat;
    logic        e_irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 16'h0000, 4'h0, 4'h0, 16'h0000, 16'h0000, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 4'h1, 4'h0, 16'h8010, 16'h0000, 1'b1},
    '{1'b0, 2'd0, 16'h0000, 4'h4, 4'h4, 16'h8050, 16'h1000, 1'b1},
    '{1'b1, 2'd0, 16'hFFFF, 4'h0, 4'h0, 16'h8050, 16'h1000, 1'b1},
    '{1'b1, 2'd0, 16'h7FFF, 4'h0, 4'h0, 16'h0050, 16'h0000, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 4'h8, 4'h0, 16'h80D0, 16'h0000, 1'b1},
    '{1'b0, 2'd0, 16'h0000, 4'h0, 4'h9, 16'h80D0, 16'h2400, 1'b1},
    '{1'b1, 2'd0, 16'h80FF, 4'h0, 4'h0, 16'h80D0, 16'h2400, 1'b1},
    '{1'b1, 2'd0, 16'h0000, 4'h0, 4'h0, 16'h0000, 16'h0000, 1'b0},
    '{1'b1, 2'd0, 16'h0000, 4'h2, 4'h0, 16'h8020, 16'h0000, 1'b1},
    '{1'b1, 2'd0, 16'h0000, 4'h0, 4'h2, 16'h0000, 16'h0800, 1'b0},
    '{1'b1, 2'd0, 16'h0000, 4'h0, 4'h0, 16'h0000, 16'h0000, 1'b0}
  };

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdreg(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(logic [3:0] dn, logic [3:0] er);
    @(negedge clk); done = dn; err = er;
    @(negedge clk); done = '0; err = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rdreg(2'd0, v); chk("R1 int", v, 16'h8080);
    rdreg(2'd1, v); chk("R1 stat", v, 16'h0000);
    rdreg(2'd2, v); chk("R1 cfg", v, 16'h40C0);
    rdreg(2'd3, v); chk("R1 cmd", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd1);
    chk("R1 ready", {15'd0, ready}, 16'd1);

    // R2 R3 R4 R9 R12 table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VECS[i].we; addr = VECS[i].addr; wdata = VECS[i].wd;
      done = VECS[i].done; err = VECS[i].err;
      @(negedge clk);
      we = 1'b0; done = '0; err = '0;
      chk($sformatf("R2/R9 irq vec%0d", i), {15'd0, irq}, {15'd0, VECS[i].e_irq});
      rdreg(2'd0, v); chk($sformatf("R2/R4/R12 int vec%0d", i), v, VECS[i].e_int);
      rdreg(2'd1, v); chk($sformatf("R3/R4/R12 stat vec%0d", i), v, VECS[i].e_stat);
    end

    // R6 accepted command
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 16'h0094;
    @(negedge clk); we = 1'b0;
    chk("R6 accept", {15'd0, accept}, 16'd1);
    chk("R6 code", code, 16'h0094);
    @(negedge clk);
    chk("R6 accept one cycle", {15'd0, accept}, 16'd0);

    // R5 refused while master set
    pulse(4'h2, 4'h0);
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 16'h0080;
    @(negedge clk); we = 1'b0;
    chk("R5 no accept", {15'd0, accept}, 16'd0);
    wr(2'd3, 16'h0055);
    rdreg(2'd1, v); chk("R5 no error", v, 16'h0000);
    rdreg(2'd3, v); chk("R5 cmd kept", v, 16'h0094);

    // R7 unknown opcode
    wr(2'd0, 16'h0000);
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 16'h0055;
    @(negedge clk); we = 1'b0;
    chk("R7 no accept", {15'd0, accept}, 16'd0);
    rdreg(2'd1, v); chk("R7 stat", v, 16'h0400);
    rdreg(2'd0, v); chk("R7 int", v, 16'h8000);
    rdreg(2'd3, v); chk("R7 cmd stored", v, 16'h0055);

    // R9 R10 polarity and ready
    wr(2'd2, 16'h0000);
    rdreg(2'd2, v); chk("R10 cfg zero", v, 16'h0000);
    chk("R10 ready low", {15'd0, ready}, 16'd0);
    chk("R9 inverted irq master set", {15'd0, irq}, 16'd0);
    wr(2'd0, 16'h0000);
    chk("R9 inverted irq master clear", {15'd0, irq}, 16'd1);
    rdreg(2'd1, v); chk("R4 errors cleared", v, 16'h0000);
    wr(2'd2, 16'h00FF);
    rdreg(2'd2, v); chk("R10 low bits hidden", v, 16'h00E0);
    chk("R10 ready high", {15'd0, ready}, 16'd1);
    chk("R9 irq", {15'd0, irq}, 16'd0);

    // R11 status write ignored, read data hold
    pulse(4'h0, 4'h4);
    wr(2'd1, 16'h0000);
    rdreg(2'd1, v); chk("R11 stat write ignored", v, 16'h1000);
    pulse(4'h1, 4'h0);
    @(negedge clk);
    chk("R11 rdata held", rdata, 16'h1000);

    // R8 reset opcode
    wr(2'd0, 16'h0000);
    pulse(4'h0, 4'h8);
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 16'h00F3;
    @(negedge clk); we = 1'b0;
    chk("R8 no accept", {15'd0, accept}, 16'd0);
    rdreg(2'd0, v); chk("R8 int", v, 16'h8010);
    rdreg(2'd1, v); chk("R8 stat", v, 16'h0000);
    rdreg(2'd2, v); chk("R8 cfg", v, 16'h40C0);
    rdreg(2'd3, v); chk("R8 cmd", v, 16'h0000);
    chk("R8 irq", {15'd0, irq}, 16'd1);

    // R8 warm reset pin
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0000);
    pulse(4'h0, 4'h1);
    @(negedge clk); warm = 1'b1;
    @(negedge clk); warm = 1'b0;
    rdreg(2'd0, v); chk("R8 warm int", v, 16'h8010);
    rdreg(2'd1, v); chk("R8 warm stat", v, 16'h0000);
    rdreg(2'd2, v); chk("R8 warm cfg", v, 16'h40C0);
    chk("R8 warm ready", {15'd0, ready}, 16'd1);

    // R6 another recognised opcode after acknowledge
    wr(2'd0, 16'h0000);
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 16'h0065;
    @(negedge clk); we = 1'b0;
    chk("R6 accept 0x65", {15'd0, accept}, 16'd1);
    chk("R6 code 0x65", code, 16'h0065);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule